// File: doc/BRIEF.md
# Module Clock Divider with Source Select and Gate

This block makes a divided module clock inside one fast clock domain. Each candidate source clock appears as an enable input that pulses once per source period. A select field picks one of these inputs. The chosen pulses pass through two divide stages: a power-of-two prescaler and then a linear divider. The block drives a level output `clk_out`, which has the divided period and a near-square duty cycle. It also drives a one-cycle `tick` that marks the start of each output period. An enable bit in the same word can gate both outputs off.

Software configures the block through one 32-bit control word, which has a write strobe and a continuous read-back. A new word does not take effect at once. It waits in a pending copy until the running output period ends, and then both divider counters restart from zero under the new settings. A build option forces the gate permanently on, for a clock that must never stop. A second option widens the source select field from 2 to 4 bits.

Top module: `modclk_gen`

## Requirements
- R1: After reset, `reg_rdata` is zero. With the forced-on option off, `clk_out` and `tick` are low.
- R2: The control word layout is as follows:
  - linear field M is at bits 3:0;
  - prescale field P is at bits 17:16;
  - source select is at bits 24 up to 24+SEL_W-1;
  - enable is at bit 31.
  
  Every other bit reads back as zero, and writes to those bits are ignored.
- R3: The total divide is D = (M+1)·2^P, which ranges from 1 to 128. While the block is enabled, `tick` pulses once every D selected-source pulses. Each tick comes in the cycle after the pulse that ends a period.
- R4: When D > 1, `clk_out` is high for the first floor(D/2) source pulses of each period and low for the rest. An even D therefore gives 50% duty, and an odd D gives a high phase one source period shorter than the low phase. When D = 1, `clk_out` stays high.
- R5: Only pulses on `src_en[SEL]` advance the divider. Pulses on the other inputs have no effect.
- R6: While the active enable is clear and the forced-on option is off, `clk_out` is held low and no `tick` is produced.
- R7: A write while the output runs takes effect at the end of the current period, so that period completes with the old settings. A write while the output is gated takes effect on the next clock.
- R8: With the forced-on option, the output runs whatever the value of bit 31. Out of reset, this means D = 1 on source 0.
- R9: `tick` is never raised without a selected-source pulse in the cycle before, so the output is never faster than the source.
- R10: When new settings load, the counters restart. The first period under the new settings is a full D source pulses long, and it starts with the high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock that all sources are sampled on |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_en | input | 2^SEL_W | One enable per source, high for one cycle per source period |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Control word to write |
| reg_rdata | output | 32 | Pending control word, with unused bits read as zero |
| clk_out | output | 1 | Divided and gated clock level |
| tick | output | 1 | One-cycle pulse at the start of each output period |

## Verification
Several properties are checked on every cycle:
- unused read-back bits stay zero;
- a gated output stays low and silent;
- settings load only at a period boundary while running;
- every tick follows a selected pulse;
- `clk_out` changes only after a pulse or a load;
- the linear counter stays within M.

Only the bench scenarios can show the actual period and high-phase lengths for each divide and source, the old period that finishes after a mid-period write, the single last tick before a gate-off, and the free-running behaviour of the forced-on build.

// File: rtl/modclk_pkg.sv
package modclk_pkg;

    // Field positions in the control word (software decodes these)
    localparam int M_LSB     = 0;
    localparam int M_W       = 4;
    localparam int P_LSB     = 16;
    localparam int P_W       = 2;
    localparam int SEL_LSB   = 24;
    localparam int SEL_MAX_W = 4;
    localparam int EN_BIT    = 31;
    localparam int DIV_W     = 8;

    typedef struct packed {
        logic                 en;
        logic [SEL_MAX_W-1:0] sel;
        logic [P_W-1:0]       p;
        logic [M_W-1:0]       m;
    } modclk_cfg_t;

    // Total divide (M+1) << P, range 1..128
    function automatic logic [DIV_W-1:0] total_div(modclk_cfg_t c);
        return ({{(DIV_W-M_W){1'b0}}, c.m} + DIV_W'(1)) << c.p;
    endfunction

    // Number of source pulses the output stays high in one period
    function automatic logic [DIV_W-1:0] high_len(modclk_cfg_t c);
        logic [DIV_W-1:0] d;
        d = total_div(c);
        return (d == DIV_W'(1)) ? DIV_W'(1) : (d >> 1);
    endfunction

endpackage

// File: rtl/modclk_cfg_reg.sv
module modclk_cfg_reg
    import modclk_pkg::*;
#(
    parameter int SEL_W    = 2,
    parameter bit FORCE_ON = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        period_end,
    output modclk_cfg_t shadow_cfg,
    output modclk_cfg_t act_cfg,
    output logic        load,
    output logic [31:0] rd_data
);

    localparam logic [SEL_MAX_W-1:0] SEL_MASK = SEL_MAX_W'((1 << SEL_W) - 1);

    typedef struct packed {
        modclk_cfg_t shadow;
        modclk_cfg_t act;
        logic        pend;
    } cfg_st_t;

    cfg_st_t st_d, st_q;
    logic    act_run;

    always_comb begin
        act_run = FORCE_ON || st_q.act.en;
        load    = st_q.pend && (period_end || !act_run);
        st_d    = st_q;
        if (load) begin
            st_d.act  = st_q.shadow;
            st_d.pend = 1'b0;
        end
        if (wr_en) begin
            st_d.shadow.m   = wr_data[M_LSB +: M_W];
            st_d.shadow.p   = wr_data[P_LSB +: P_W];
            st_d.shadow.sel = wr_data[SEL_LSB +: SEL_MAX_W] & SEL_MASK;
            st_d.shadow.en  = wr_data[EN_BIT];
            st_d.pend       = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data                        = '0;
        rd_data[M_LSB +: M_W]          = st_q.shadow.m;
        rd_data[P_LSB +: P_W]          = st_q.shadow.p;
        rd_data[SEL_LSB +: SEL_MAX_W]  = st_q.shadow.sel;
        rd_data[EN_BIT]                = st_q.shadow.en;
    end

    assign shadow_cfg = st_q.shadow;
    assign act_cfg    = st_q.act;

endmodule

// File: rtl/modclk_src_sel.sv
module modclk_src_sel #(
    parameter int SEL_W     = 2,
    parameter int SEL_MAX_W = 4
) (
    input  logic [(1<<SEL_W)-1:0] src_en,
    input  logic [SEL_MAX_W-1:0]  sel,
    output logic                  pulse
);

    localparam int NSRC = 1 << SEL_W;

    logic [NSRC-1:0] hit;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign hit[i] = src_en[i] && (sel[SEL_W-1:0] == SEL_W'(i));
    end

    assign pulse = |hit;

endmodule

// File: rtl/modclk_divider.sv
module modclk_divider
    import modclk_pkg::*;
#(
    parameter bit FORCE_ON = 1'b0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pulse,
    input  logic           load,
    input  modclk_cfg_t    act_cfg,
    input  modclk_cfg_t    shadow_cfg,
    output logic           period_end,
    output logic           clk_out,
    output logic           tick,
    output logic [M_W-1:0] mcnt
);

    localparam int PCNT_W = (1 << P_W) - 1;

    typedef struct packed {
        logic [PCNT_W-1:0] pcnt;
        logic [M_W-1:0]    mcnt;
        logic              clk_o;
        logic              tick;
    } div_st_t;

    div_st_t           st_d, st_q;
    logic              run;
    logic [PCNT_W-1:0] pmax;
    logic              wrap_p;
    logic              wrap_m;
    logic [DIV_W-1:0]  pos_n;

    always_comb begin
        run        = FORCE_ON || act_cfg.en;
        pmax       = PCNT_W'((4'd1 << act_cfg.p) - 4'd1);
        wrap_p     = (st_q.pcnt == pmax);
        wrap_m     = (st_q.mcnt == act_cfg.m);
        period_end = run && pulse && wrap_p && wrap_m;

        st_d      = st_q;
        st_d.tick = period_end;
        if (load || !run) begin
            st_d.pcnt = '0;
            st_d.mcnt = '0;
        end else if (pulse) begin
            if (wrap_p) begin
                st_d.pcnt = '0;
                st_d.mcnt = wrap_m ? '0 : M_W'(st_q.mcnt + 1'b1);
            end else begin
                st_d.pcnt = PCNT_W'(st_q.pcnt + 1'b1);
            end
        end

        // position within the period, in source pulses
        pos_n = ({{(DIV_W-M_W){1'b0}}, st_d.mcnt} << act_cfg.p)
              | {{(DIV_W-PCNT_W){1'b0}}, st_d.pcnt};

        if (load) st_d.clk_o = FORCE_ON || shadow_cfg.en;
        else      st_d.clk_o = run && (pos_n < high_len(act_cfg));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign clk_out = st_q.clk_o;
    assign tick    = st_q.tick;
    assign mcnt    = st_q.mcnt;

endmodule

// File: rtl/modclk_gen.sv
module modclk_gen
    import modclk_pkg::*;
#(
    parameter int SEL_W    = 2,
    parameter bit FORCE_ON = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [(1<<SEL_W)-1:0] src_en,
    input  logic                  reg_wr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    output logic                  clk_out,
    output logic                  tick
);

    modclk_cfg_t    shadow_cfg;
    modclk_cfg_t    act_cfg;
    logic           cfg_load;
    logic           sel_pulse;
    logic           period_end;
    logic [M_W-1:0] div_mcnt;

    modclk_cfg_reg #(
        .SEL_W   (SEL_W),
        .FORCE_ON(FORCE_ON)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .wr_data   (reg_wdata),
        .period_end(period_end),
        .shadow_cfg(shadow_cfg),
        .act_cfg   (act_cfg),
        .load      (cfg_load),
        .rd_data   (reg_rdata)
    );

    modclk_src_sel #(
        .SEL_W    (SEL_W),
        .SEL_MAX_W(SEL_MAX_W)
    ) u_sel (
        .src_en(src_en),
        .sel   (act_cfg.sel),
        .pulse (sel_pulse)
    );

    modclk_divider #(
        .FORCE_ON(FORCE_ON)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .pulse     (sel_pulse),
        .load      (cfg_load),
        .act_cfg   (act_cfg),
        .shadow_cfg(shadow_cfg),
        .period_end(period_end),
        .clk_out   (clk_out),
        .tick      (tick),
        .mcnt      (div_mcnt)
    );

endmodule

// File: rtl/modclk_gen_chk.sv
module modclk_gen_chk
    import modclk_pkg::*;
#(
    parameter int SEL_W    = 2,
    parameter bit FORCE_ON = 1'b0
) (
    input logic           clk,
    input logic           rst_n,
    input logic [31:0]    reg_rdata,
    input logic           clk_out,
    input logic           tick,
    input logic           pulse,
    input logic           load,
    input logic           period_end,
    input modclk_cfg_t    act_cfg,
    input logic [M_W-1:0] mcnt
);

    localparam logic [31:0] USED = 32'h8003_000F | (32'((1 << SEL_W) - 1) << SEL_LSB);

    logic act_run;
    assign act_run = FORCE_ON || act_cfg.en;

    // R2
    rdata_unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & ~USED) == 32'h0);

    // R6
    gated_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_run && !load) |=> (!clk_out && !tick));

    // R7
    load_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && act_run) |-> period_end);

    // R9
    tick_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(pulse));

    // R4
    out_moves_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(pulse) || $past(load)) |-> $stable(clk_out));

    // R3
    mcnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mcnt <= act_cfg.m);

endmodule

bind modclk_gen modclk_gen_chk #(
    .SEL_W   (SEL_W),
    .FORCE_ON(FORCE_ON)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rdata (reg_rdata),
    .clk_out   (clk_out),
    .tick      (tick),
    .pulse     (sel_pulse),
    .load      (cfg_load),
    .period_end(period_end),
    .act_cfg   (act_cfg),
    .mcnt      (div_mcnt)
);

// File: tb/modclk_gen_bench.sv
`timescale 1ns/1ps
module modclk_gen_bench;

    typedef struct {
        int    period;
        int    high;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src4 = 4'b0;
    logic [15:0] src16;
    logic        reg_wr = 1'b0, aon_wr = 1'b0;
    logic [31:0] reg_wdata = '0, aon_wdata = '0;
    logic [31:0] reg_rdata, aon_rdata;
    logic        clk_out, tick, aon_clk, aon_tick;

    int   n_cmp = 0, n_bad = 0;
    int   cyc = 0;
    int   sync_id = 0, seen_id = 0;
    int   tick_seen = 0;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    assign src16 = {4{src4}};

    // source pulse spacings: src0 every 1, src1 every 3, src2 every 2, src3 every 5
    always @(negedge clk) begin
        cyc <= cyc + 1;
        src4[0] <= 1'b1;
        src4[1] <= ((cyc + 1) % 3 == 0);
        src4[2] <= ((cyc + 1) % 2 == 0);
        src4[3] <= ((cyc + 1) % 5 == 0);
    end

    modclk_gen #(.SEL_W(2), .FORCE_ON(1'b0)) u_modclk_gen (
        .clk(clk), .rst_n(rst_n), .src_en(src4), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clk_out(clk_out), .tick(tick)
    );

    modclk_gen #(.SEL_W(4), .FORCE_ON(1'b1)) u_modclk_gen_aon (
        .clk(clk), .rst_n(rst_n), .src_en(src16), .reg_wr(aon_wr),
        .reg_wdata(aon_wdata), .reg_rdata(aon_rdata), .clk_out(aon_clk), .tick(aon_tick)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int spacing(input int sel);
        case (sel)
            0: return 1;
            1: return 3;
            2: return 2;
            default: return 5;
        endcase
    endfunction

    function automatic logic [31:0] word(input int m, input int p, input int sel, input bit en);
        return {en, 3'b0, 4'(sel), 6'b0, 2'(p), 12'b0, 4'(m)};
    endfunction

    // monitor: measures period and high length between ticks, pops expectations
    always begin
        @(negedge clk); #1;
        if (rst_n) begin
            if (seen_id != sync_id) begin
                seen_id = sync_id;
                mon_in = 1'b0;
            end
            if (tick) begin
                tick_seen++;
                if (mon_in && sb_q.size() > 0) begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(mon_len == e.period, e.tag, "period", mon_len, e.period);
                    check(mon_hi == e.high, e.tag, "high length", mon_hi, e.high);
                end
                mon_in  = 1'b1;
                mon_len = 1;
                mon_hi  = clk_out ? 1 : 0;
            end else if (mon_in) begin
                mon_len++;
                if (clk_out) mon_hi++;
            end
        end
    end
    bit mon_in = 1'b0;
    int mon_len = 0, mon_hi = 0;

    task automatic sample();
        @(negedge clk); #2;
    endtask

    task automatic reg_write(input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic aon_write(input logic [31:0] d);
        @(negedge clk);
        aon_wr = 1'b1; aon_wdata = d;
        @(negedge clk);
        aon_wr = 1'b0;
    endtask

    task automatic wait_tick();
        int n = 0;
        do begin sample(); n++; end while (!tick && n < 3000);
        check(n < 3000, "R3", "tick seen before timeout", n, 0);
    endtask

    task automatic push_exp(input int m, input int p, input int sel, input int n, input string tag);
        int d, h, s;
        d = (m + 1) << p;
        h = (d == 1) ? 1 : d / 2;
        s = spacing(sel);
        for (int i = 0; i < n; i++) sb_q.push_back('{d * s, h * s, tag});
    endtask

    task automatic drain();
        int n = 0;
        while (sb_q.size() > 0 && n < 5000) begin sample(); n++; end
        check(sb_q.size() == 0, "R3", "scoreboard drained", sb_q.size(), 0);
        sb_q.delete();
    endtask

    task automatic run_cfg(input int m, input int p, input int sel, input int n, input string tag);
        reg_write(word(m, p, sel, 1'b1));
        wait_tick();
        sync_id++;
        push_exp(m, p, sel, n, tag);
        drain();
    endtask

    initial begin
        int t0, first_tick, hi_cnt, lo_after, ticks;
        logic [3:0] pat;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) sample();

        // R1 reset state
        check(reg_rdata == 32'h0, "R1", "rdata after reset", reg_rdata, 0);
        check(clk_out == 1'b0, "R1", "clk_out after reset", clk_out, 0);
        check(tick == 1'b0, "R1", "tick after reset", tick, 0);
        // R8 forced-on build runs D=1 on source 0 out of reset
        check(aon_clk == 1'b1, "R8", "forced-on clk_out after reset", aon_clk, 1);
        check(aon_tick == 1'b1, "R8", "forced-on tick after reset", aon_tick, 1);

        // R2 unused bits ignored, field bits kept
        reg_write(32'h7CFC_FFF0);
        sample();
        check(reg_rdata == 32'h0, "R2", "unused bits read zero", reg_rdata, 0);
        reg_write(32'h7FFF_FFFF);
        sample();
        check(reg_rdata == 32'h0303_000F, "R2", "field bits read back", reg_rdata, 32'h0303_000F);

        // R6 gated: no tick, output low
        t0 = tick_seen; hi_cnt = 0;
        for (int i = 0; i < 200; i++) begin sample(); if (clk_out) hi_cnt++; end
        check(tick_seen == t0, "R6", "ticks while gated", tick_seen - t0, 0);
        check(hi_cnt == 0, "R6", "high samples while gated", hi_cnt, 0);

        // R10 / R7 enable from gated: loads next clock, full first period high first
        reg_write(word(3, 0, 0, 1'b1));
        first_tick = 0; pat = '0;
        for (int i = 1; i <= 8; i++) begin
            sample();
            if (i <= 4) pat[i-1] = clk_out;
            if (tick && first_tick == 0) first_tick = i;
        end
        check(pat == 4'b0011, "R10", "first period shape (samples 1..4)", pat, 4'b0011);
        check(first_tick == 5, "R10", "first tick sample index", first_tick, 5);
        check(pat[0] == 1'b1, "R7", "gated write takes effect next clock", pat[0], 1);

        // scoreboard scenarios
        run_cfg(0, 0, 0, 3, "R3 R4 D=1 held high");
        run_cfg(1, 0, 0, 3, "R3 R4 D=2 even");
        run_cfg(2, 0, 2, 3, "R4 R5 D=3 odd on src2");
        run_cfg(3, 2, 1, 2, "R3 R5 D=16 on src1");
        run_cfg(4, 1, 3, 2, "R3 R5 R9 D=10 on src3");
        run_cfg(15, 3, 0, 2, "R3 R4 D=128 maximum");

        // R7 mid-period write: old period completes, then new settings
        wait_tick();
        repeat (10) sample();
        reg_write(word(1, 0, 0, 1'b1));
        sb_q.push_back('{128, 64, "R7 old period kept"});
        push_exp(1, 0, 0, 3, "R7 new period after boundary");
        drain();

        // R6 / R7 gate off mid-period: exactly one more tick, then low
        run_cfg(4, 1, 3, 1, "R3 D=10 before gate-off");
        wait_tick();
        repeat (5) sample();
        reg_write(word(4, 1, 3, 1'b0));
        t0 = tick_seen; lo_after = 0;
        for (int i = 0; i < 200; i++) begin
            sample();
            if (i >= 100 && clk_out) lo_after++;
        end
        check(tick_seen - t0 == 1, "R7", "ticks after gate-off write", tick_seen - t0, 1);
        check(lo_after == 0, "R6", "high samples after gate-off", lo_after, 0);

        // R8 forced-on build ignores bit 31
        aon_write(32'h7FFF_FFFF);
        sample();
        check(aon_rdata == 32'h0F03_000F, "R2", "wide select read back", aon_rdata, 32'h0F03_000F);
        aon_write(word(2, 0, 1, 1'b0));
        repeat (1400) sample();
        ticks = 0; hi_cnt = 0;
        for (int i = 0; i < 90; i++) begin
            sample();
            if (aon_tick) ticks++;
            if (aon_clk) hi_cnt++;
        end
        check(ticks == 10, "R8", "ticks in 90 cycles with bit31 clear", ticks, 10);
        check(hi_cnt == 30, "R8", "high cycles in 90 with bit31 clear", hi_cnt, 30);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", 150000, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule